// File: doc/BRIEF.md
# Multi-width configuration data shifter

This block turns a stream of uncompressed configuration bytes into slices on a configuration data bus and drives the configuration clock for them. One shifter can feed a single serial chain, or 2, 4 or 8 independent serial chains at once, with one bit per chain on each clock. It can also act as a byte-wide parallel port. Data lines above the selected width are held low.

Bytes arrive on a valid/ready stream. The block takes a byte only when it is idle. It sends that byte lowest slice first, one slice per configuration clock, and accepts the next byte only after the final slice has been clocked out. The configuration clock rate is set by a half-period divider. The clock rests low and stops whenever no byte is available. Readiness of the targets, the flash read path and decompression are handled by an outside sequencer.

Top module: `cfg_shifter`

## Requirements
- R1: After reset, `cfg_clk` is low, `cfg_data` is all zero and `in_ready` is high.
- R2: With `width_sel` = 0 (one lane), a byte goes out on `cfg_data[0]` one bit per `cfg_clk` rising edge, least significant bit first, over 8 clocks.
- R3: With `width_sel` = 1 (two lanes) or 2 (four lanes), a byte goes out in n-bit slices, lowest slice first, over 8/n clocks. Within each slice, `cfg_data[0]` carries the lowest bit.
- R4: With `width_sel` = 3 (eight lanes), the whole byte appears on `cfg_data[7:0]` for a single `cfg_clk` rising edge.
- R5: When `par_mode` is high at acceptance, the byte is sent as one 8-bit word on one clock, whatever `width_sel` holds.
- R6: Data lines at or above the active lane count are driven low.
- R7: `cfg_data` changes only while `cfg_clk` is low. A new slice appears at the falling edge, or at acceptance, and is held for the whole high phase.
- R8: Every high phase and every low phase inside a byte lasts `div_half`+1 system clocks, which gives a range of 1 to 16.
- R9: `in_ready` is high only while idle. It is never high while `cfg_clk` is high, and it returns high in the same cycle as the falling edge that ends the last slice.
- R10: While idle with `in_valid` low, `cfg_clk` stays low and `cfg_data` holds its value.
- R11: Changes to `width_sel`, `par_mode`, `div_half` or `in_data` after a byte has been accepted do not affect that byte's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 2 | Lane count as log2: 0→1, 1→2, 2→4, 3→8 |
| par_mode | input | 1 | Byte-wide parallel port mode; overrides width_sel |
| div_half | input | 4 | Half period of cfg_clk in system clocks, minus one |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block is idle and will take a byte |
| cfg_clk | output | 1 | Configuration clock, rests low |
| cfg_data | output | 8 | Configuration data lines |

## Verification
The hardest case to reach from the ports is a configuration change during a byte. The block only latches width, mode and divider at acceptance, so a bench that changes inputs only between bytes never shows whether the latch works. The stimulus therefore inverts `width_sel`, `par_mode`, `div_half` and `in_data` in the cycle after the handshake. It then checks that the slice count, slice values and phase lengths still follow the settings that were latched. Phase lengths are measured per edge at both ends of the divider range.

// File: rtl/cfg_shift_pkg.sv
package cfg_shift_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } shift_state_t;

   // Pick the lane exponent: parallel mode or an out-of-range select
   // both fall back to the full bus width.
   function automatic int unsigned lane_exp(input int unsigned sel,
                                            input logic par,
                                            input int unsigned max_exp);
      if (par || sel > max_exp) return max_exp;
      return sel;
   endfunction

endpackage

// File: rtl/cfg_half_timer.sv
module cfg_half_timer #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] half_len,
   output logic             tick
);

   logic [DIV_W-1:0] len_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         len_q <= half_len;
         cnt_q <= half_len;
      end else if (run) begin
         if (cnt_q == '0) cnt_q <= len_q;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/cfg_slicer.sv
module cfg_slicer #(
   parameter int BUS_W = 8,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [BUS_W-1:0] byte_in,
   input  logic [SEL_W-1:0] lane_exp_cur,
   output logic [BUS_W-1:0] lines
);

   logic [BUS_W-1:0] lane_mask;
   logic [BUS_W-1:0] shreg_q;
   logic [BUS_W-1:0] out_q;

   // One enable per output line: line i is live when i < 2**exp.
   for (genvar i = 0; i < BUS_W; i++) begin : g_lane
      assign lane_mask[i] = (i < (32'd1 << lane_exp_cur));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         out_q   <= '0;
      end else if (load) begin
         out_q   <= byte_in & lane_mask;
         shreg_q <= byte_in >> (32'd1 << lane_exp_cur);
      end else if (step) begin
         out_q   <= shreg_q & lane_mask;
         shreg_q <= shreg_q >> (32'd1 << lane_exp_cur);
      end
   end

   assign lines = out_q;

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
   parameter int BUS_W = 8,
   parameter int DIV_W = 4,
   parameter int SEL_W = $clog2($clog2(BUS_W) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] width_sel,
   input  logic             par_mode,
   input  logic [DIV_W-1:0] div_half,
   input  logic [BUS_W-1:0] in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             cfg_clk,
   output logic [BUS_W-1:0] cfg_data
);
   import cfg_shift_pkg::*;

   localparam int LOG_W = $clog2(BUS_W);
   localparam int REM_W = (LOG_W < 1) ? 1 : LOG_W;

   if (BUS_W < 2 || (BUS_W & (BUS_W - 1)) != 0) begin : g_bad_bus
      $error("cfg_shifter: BUS_W must be a power of two, at least 2");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("cfg_shifter: DIV_W out of range");
   end
   if ((1 << SEL_W) <= LOG_W) begin : g_bad_sel
      $error("cfg_shifter: SEL_W too narrow for BUS_W");
   end

   shift_state_t     state_q;
   logic [SEL_W-1:0] llog_d, llog_q, llog_cur;
   logic [REM_W-1:0] rem_q;
   logic             clk_q;
   logic             accept, tick, step;

   assign llog_d   = SEL_W'(lane_exp(int'(width_sel), par_mode, LOG_W));
   assign accept   = (state_q == ST_IDLE) && in_valid;
   assign step     = (state_q == ST_HIGH) && tick && (rem_q != '0);
   assign llog_cur = accept ? llog_d : llog_q;
   assign in_ready = (state_q == ST_IDLE);
   assign cfg_clk  = clk_q;

   cfg_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .run      (state_q != ST_IDLE),
      .half_len (div_half),
      .tick     (tick)
   );

   cfg_slicer #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_slicer (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (accept),
      .step         (step),
      .byte_in      (in_data),
      .lane_exp_cur (llog_cur),
      .lines        (cfg_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         clk_q   <= 1'b0;
         rem_q   <= '0;
         llog_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (in_valid) begin
               llog_q  <= llog_d;
               rem_q   <= REM_W'((BUS_W >> llog_d) - 1);
               state_q <= ST_LOW;
            end
            ST_LOW: if (tick) begin
               clk_q   <= 1'b1;
               state_q <= ST_HIGH;
            end
            ST_HIGH: if (tick) begin
               clk_q <= 1'b0;
               if (rem_q == '0) begin
                  state_q <= ST_IDLE;
               end else begin
                  rem_q   <= rem_q - 1'b1;
                  state_q <= ST_LOW;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfg_shifter_chk.sv
module cfg_shifter_chk #(
   parameter int BUS_W = 8,
   parameter int SEL_W = 2,
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             cfg_clk,
   input logic [BUS_W-1:0] cfg_data,
   input logic [SEL_W-1:0] llog_q
);

   logic [DIV_W:0] hi_run;

   always_ff @(posedge clk) begin
      if (!rst_n)       hi_run <= '0;
      else if (cfg_clk) hi_run <= hi_run + 1'b1;
      else              hi_run <= '0;
   end

   a_r6_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_data >> (32'd1 << llog_q)) == '0));

   a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk |-> $stable(cfg_data));

   a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !cfg_clk);

   a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_clk) |-> !in_ready);

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (!cfg_clk && $stable(cfg_data)));

   a_r8_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(hi_run) <= (1 << DIV_W)));

endmodule

bind cfg_shifter cfg_shifter_chk #(.BUS_W(BUS_W), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .cfg_clk  (cfg_clk),
   .cfg_data (cfg_data),
   .llog_q   (llog_q)
);

// File: tb/cfg_shifter_bench.sv
module cfg_shifter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] width_sel = '0;
   logic       par_mode = 1'b0;
   logic [3:0] div_half = '0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       cfg_clk;
   logic [7:0] cfg_data;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   cfg_shifter u_cfg_shifter (
      .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .par_mode(par_mode),
      .div_half(div_half), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .cfg_clk(cfg_clk), .cfg_data(cfg_data)
   );

   // Monitor state, sampled on the falling system clock edge.
   logic [7:0] caps [0:15];
   int   ncap = 0;
   int   exp_half = 1;
   int   lo_cnt = 0, hi_cnt = 0;
   int   bad_timing = 0, bad_stable = 0, bad_ready = 0;
   int   ready_fall_idx = -1;
   logic prev_clk = 1'b0;
   logic [7:0] prev_data = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (in_ready && cfg_clk) bad_ready++;
         if (cfg_clk) begin
            if (!prev_clk) begin
               if (lo_cnt != exp_half) bad_timing++;
               lo_cnt = 0;
               if (ncap < 16) caps[ncap] = cfg_data;
               ncap++;
            end else if (cfg_data != prev_data) begin
               bad_stable++;
            end
            hi_cnt++;
         end else begin
            if (prev_clk) begin
               if (hi_cnt != exp_half) bad_timing++;
               hi_cnt = 0;
               if (in_ready) ready_fall_idx = ncap;
            end
            if (!in_ready) lo_cnt++;
         end
      end
      prev_clk  = cfg_clk;
      prev_data = cfg_data;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_byte(input logic [7:0] b, input logic [1:0] sel, input logic par,
                           input logic [3:0] div, input bit disturb, input string req);
      int lanes, slices, guard;
      logic [7:0] mask, expv;
      lanes  = par ? 8 : (1 << sel);
      slices = 8 / lanes;
      mask   = 8'((16'd1 << lanes) - 1);
      @(negedge clk);
      ncap = 0; bad_timing = 0; bad_stable = 0; bad_ready = 0;
      ready_fall_idx = -1; lo_cnt = 0; hi_cnt = 0; exp_half = int'(div) + 1;
      width_sel = sel; par_mode = par; div_half = div; in_data = b; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (disturb) begin
         width_sel = ~sel; par_mode = ~par; div_half = ~div; in_data = ~b;
      end
      chk(in_ready == 1'b0, "R9 busy after accept", int'(in_ready), 0);
      guard = 0;
      while (!in_ready && guard < 2000) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      chk(ncap == slices, {req, " slice count"}, ncap, slices);
      for (int k = 0; k < slices && k < ncap && k < 16; k++) begin
         expv = (b >> (k * lanes)) & mask;
         chk(caps[k] == expv, {req, " slice value"}, int'(caps[k]), int'(expv));
         chk((caps[k] & ~mask) == 8'h00, "R6 unused lines low", int'(caps[k] & ~mask), 0);
      end
      chk(bad_timing == 0, "R8 phase length", bad_timing, 0);
      chk(bad_stable == 0, "R7 data stable while high", bad_stable, 0);
      chk(bad_ready == 0, "R9 ready while clock high", bad_ready, 0);
      chk(ready_fall_idx == slices, "R9 ready at last fall", ready_fall_idx, slices);
      width_sel = '0; par_mode = 1'b0; div_half = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cfg_clk == 1'b0, "R1 clock low", int'(cfg_clk), 0);
      chk(cfg_data == 8'h00, "R1 data zero", int'(cfg_data), 0);
      chk(in_ready == 1'b1, "R1 ready high", int'(in_ready), 1);
   endtask

   task automatic t_idle();
      logic [7:0] held;
      @(negedge clk);
      held = cfg_data;
      ncap = 0;
      repeat (40) @(negedge clk);
      chk(ncap == 0, "R10 no clock edges idle", ncap, 0);
      chk(cfg_clk == 1'b0, "R10 clock low idle", int'(cfg_clk), 0);
      chk(cfg_data == held, "R10 data held idle", int'(cfg_data), int'(held));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_byte(8'hA5, 2'd0, 1'b0, 4'd0,  1'b0, "R2 one lane");
      run_byte(8'h6C, 2'd1, 1'b0, 4'd2,  1'b0, "R3 two lanes");
      run_byte(8'h3B, 2'd2, 1'b0, 4'd5,  1'b0, "R3 four lanes");
      run_byte(8'hD2, 2'd3, 1'b0, 4'd15, 1'b0, "R4 eight lanes");
      run_byte(8'h81, 2'd0, 1'b1, 4'd1,  1'b0, "R5 parallel override");
      t_idle();
      run_byte(8'h4E, 2'd1, 1'b0, 4'd3,  1'b1, "R11 change while busy");
      run_byte(8'h17, 2'd0, 1'b0, 4'd1,  1'b1, "R11 change while busy");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule